// File: doc/BRIEF.md
# Asynchronous SRAM Pin-Level Target Emulator

This block stands in for an asynchronous static RAM at its pins so that a memory controller can be tried on an FPGA before the real device is fitted. A fast sampling clock oversamples every pin through a two-flop synchronizer. The block then works out the operation from the levels of the two chip selects, the width-mode pin, the two byte enables, write enable and output enable. Storage is an internal register array of 16-bit words whose depth follows the address width parameter. The bidirectional data bus is split into an input vector, an output vector and one output-enable per lane, and the board-level wrapper puts these onto tri-state pads.

The block works in one of two widths. In word mode the two byte enables pick the lower and upper lanes of the addressed word. In byte mode only the lower eight data lines carry data. Data line 15 then becomes an input that picks the lower half (0) or the upper half (1) of the stored word. A write is held open for as long as both chip selects are active, write enable is low and at least one byte enable is low. The byte lanes captured during the last sampled cycle of that window are committed on the first edge that closes it. A read is modelled with a latency counted in sample cycles. Until the read is valid the driven lanes carry zeros and a status output stays low.

The control path is a state machine with five states. IDLE means deselected. WRITE means a write window is open. READ_WAIT counts the access latency. READ_OUT drives valid data. OUT_OFF means selected with the outputs disabled. Its transitions are as follows. Open-window goes from any state to WRITE. Start-read goes from IDLE, WRITE or OUT_OFF to READ_WAIT. Latency-done goes from READ_WAIT to READ_OUT. Key-change goes from READ_OUT to READ_WAIT, or restarts the count inside READ_WAIT, whenever the address, width, half select or enables change. Disable goes to OUT_OFF when both write enable and output enable are high. Deselect goes from any state to IDLE.

Top module: `sram_pin_target`

## Requirements
- R1: When chip select 1 (`cs1_n`) is high or chip select 2 (`cs2`) is low, no lane is driven, `rd_valid` is 0, and no word is written, whatever the other pins do.
- R2: When both byte enables (`lo_en_n`, `hi_en_n`) are high, no lane is driven and no write takes place, even with write enable low.
- R3: With the chip selected, a byte enable low and `we_n` low, a write happens whether `oe_n` is high or low, and neither lane is driven while the window is open.
- R4: With the chip selected, `we_n` high and `oe_n` low, a read drives the enabled lanes. With both `we_n` and `oe_n` high, nothing is driven.
- R5: In word mode (`narrow_n`=1), `lo_en_n` alone gates data bits 7:0 and `hi_en_n` alone gates bits 15:8, for both writes and reads. `dq_oe_lo` covers bits 7:0 and `dq_oe_hi` covers bits 15:8.
- R6: In byte mode (`narrow_n`=0), only bits 7:0 move data and `dq_oe_hi` stays 0. `dq_in[15]` picks the half of the word at `addr`: 0 is bits 7:0 and 1 is bits 15:8. A byte read returns that half on `dq_out[7:0]`.
- R7: A write stores the data and lanes held in the last sampled cycle of the window. Any data change after the first closing edge, whether it is `we_n` rising or `cs1_n` rising, is not stored.
- R8: After a change of address, width, half select or enables during a read, `rd_valid` falls 3 clocks later. It rises again LAT clocks after that (LAT=3 by default, so 6 clocks after the change). While `rd_valid` is 0, `dq_out` is all zeros.
- R9: `proto_err` goes to 1 when byte mode is used while the chip is selected and either byte enable is high. It then stays at 1 until reset.
- R10: After reset the state is IDLE, no lane is driven, `rd_valid` and `proto_err` are 0, and every stored word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2 | input | 1 | Chip select 2, active high |
| narrow_n | input | 1 | 0 selects byte mode, 1 selects word mode |
| lo_en_n | input | 1 | Lower lane enable, active low |
| hi_en_n | input | 1 | Upper lane enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data pins as seen by the target; bit 15 is the half select in byte mode |
| dq_out | output | 16 | Data driven by the target |
| dq_oe_lo | output | 1 | Drive enable for bits 7:0 |
| dq_oe_hi | output | 1 | Drive enable for bits 15:8 |
| rd_valid | output | 1 | Read data has met the modelled latency |
| proto_err | output | 1 | Sticky flag for byte mode used with a byte enable high |

## Verification
Full-word writes and reads, together with single-lane writes, tell apart a correct lane mask from one that swaps or merges the lanes. Byte-mode writes and reads of both halves of one word show whether the half select has been taken from data bit 15. Windows closed by write enable and windows closed by chip select, each followed by a data change, separate a commit on the first closing edge from one that samples late. Deselected, both-enables-high and output-disabled patterns confirm that nothing is written or driven. An address change during a read is timed clock by clock to pin down the latency.

// File: rtl/sram_pin_pkg.sv
package sram_pin_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WRITE     = 3'd1,
        ST_READ_WAIT = 3'd2,
        ST_READ_OUT  = 3'd3,
        ST_OUT_OFF   = 3'd4
    } tgt_state_e;

    localparam int LANE_W   = 8;
    localparam int LANES    = 2;
    localparam int DATA_W   = LANE_W * LANES;
    localparam int CTRL_W   = 7;
    localparam int SYNC_DEP = 2;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] synced
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= rst_val;
                end else if (g == 0) begin
                    stage_q[g] <= raw;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/word_store.sv
module word_store
    import sram_pin_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem[i][l*LANE_W +: LANE_W] <= '0;
                    end
                end else if (wr_en && wr_mask[l]) begin
                    mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
                end
            end
        end
    endgenerate

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sram_pin_fsm.sv
module sram_pin_fsm
    import sram_pin_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_ok,
    input  logic              narrow,
    input  logic              lo_n,
    input  logic              hi_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output tgt_state_e        st,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_mask,
    output logic [DATA_W-1:0] wr_data,
    output logic              drv_lo,
    output logic              drv_hi,
    output logic              valid,
    output logic              err
);
    localparam int CW    = $clog2(LAT) + 1;
    localparam int KEY_W = ADDR_W + 4;

    tgt_state_e        st_next;
    logic [CW-1:0]     cnt_q, cnt_next;
    logic [KEY_W-1:0]  key, key_q;
    logic              any_en, window, rcond, half;
    logic [ADDR_W-1:0] hold_addr;
    logic [LANES-1:0]  hold_mask;
    logic [DATA_W-1:0] hold_data;
    logic              err_q;

    assign half   = dq_in[DATA_W-1];
    assign any_en = !lo_n || !hi_n;
    assign window = cs_ok && any_en && !we_n;
    assign rcond  = cs_ok && any_en && we_n && !oe_n;
    assign key    = {addr, narrow, narrow & half, lo_n, hi_n};

    always_comb begin
        st_next  = st;
        cnt_next = cnt_q;
        if (!cs_ok || !any_en) begin
            st_next  = ST_IDLE;
            cnt_next = '0;
        end else if (window) begin
            st_next  = ST_WRITE;
            cnt_next = '0;
        end else if (!rcond) begin
            st_next  = ST_OUT_OFF;
            cnt_next = '0;
        end else begin
            unique case (st)
                ST_READ_WAIT: begin
                    if (key != key_q) begin
                        cnt_next = '0;
                    end else if (cnt_q == CW'(LAT - 1)) begin
                        st_next = ST_READ_OUT;
                    end else begin
                        cnt_next = cnt_q + 1'b1;
                    end
                end
                ST_READ_OUT: begin
                    if (key != key_q) begin
                        st_next  = ST_READ_WAIT;
                        cnt_next = '0;
                    end
                end
                ST_IDLE, ST_WRITE, ST_OUT_OFF: begin
                    st_next  = ST_READ_WAIT;
                    cnt_next = '0;
                end
                default: begin
                    st_next  = ST_IDLE;
                    cnt_next = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt_q     <= '0;
            key_q     <= '0;
            hold_addr <= '0;
            hold_mask <= '0;
            hold_data <= '0;
            err_q     <= 1'b0;
        end else begin
            st    <= st_next;
            cnt_q <= cnt_next;
            key_q <= key;
            if (window) begin
                hold_addr <= addr;
                if (narrow) begin
                    hold_mask <= half ? 2'b10 : 2'b01;
                    hold_data <= {dq_in[LANE_W-1:0], dq_in[LANE_W-1:0]};
                end else begin
                    hold_mask <= {!hi_n, !lo_n};
                    hold_data <= dq_in;
                end
            end
            if (cs_ok && narrow && (lo_n || hi_n)) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        wr_en   = (st == ST_WRITE) && !window;
        wr_addr = hold_addr;
        wr_mask = hold_mask;
        wr_data = hold_data;
        valid   = (st == ST_READ_OUT);
        err     = err_q;
        drv_lo  = 1'b0;
        drv_hi  = 1'b0;
        if (st == ST_READ_WAIT || st == ST_READ_OUT) begin
            drv_lo = narrow ? 1'b1 : !lo_n;
            drv_hi = narrow ? 1'b0 : !hi_n;
        end
    end
endmodule

// File: rtl/sram_pin_target.sv
module sram_pin_target
    import sram_pin_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              narrow_n,
    input  logic              lo_en_n,
    input  logic              hi_en_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic              dq_oe_lo,
    output logic              dq_oe_hi,
    output logic              rd_valid,
    output logic              proto_err
);
    localparam int PW = CTRL_W + ADDR_W + DATA_W;

    logic [PW-1:0]     pins_raw, pins_s, pins_rst;
    logic              cs1_s, cs2_s, narrow_n_s, lo_s, hi_s, we_s, oe_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] dq_s;
    logic              narrow_s;
    tgt_state_e        st;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [LANES-1:0]  wr_mask;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic              drv_lo, drv_hi, valid, err;

    assign pins_raw = {cs1_n, cs2, narrow_n, lo_en_n, hi_en_n, we_n, oe_n, addr, dq_in};
    assign pins_rst = {7'b1011111, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

    pin_sync #(.W(PW), .STAGES(SYNC_DEP)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (pins_raw),
        .rst_val (pins_rst),
        .synced  (pins_s)
    );

    assign {cs1_s, cs2_s, narrow_n_s, lo_s, hi_s, we_s, oe_s, addr_s, dq_s} = pins_s;
    assign narrow_s = !narrow_n_s;

    sram_pin_fsm #(.ADDR_W(ADDR_W), .LAT(LAT)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_ok   (!cs1_s && cs2_s),
        .narrow  (narrow_s),
        .lo_n    (lo_s),
        .hi_n    (hi_s),
        .we_n    (we_s),
        .oe_n    (oe_s),
        .addr    (addr_s),
        .dq_in   (dq_s),
        .st      (st),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .drv_lo  (drv_lo),
        .drv_hi  (drv_hi),
        .valid   (valid),
        .err     (err)
    );

    word_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .rd_addr (addr_s),
        .rd_data (rd_data)
    );

    always_comb begin
        dq_out = '0;
        if (valid) begin
            if (narrow_s) begin
                dq_out[7:0] = dq_s[DATA_W-1] ? rd_data[15:8] : rd_data[7:0];
            end else begin
                dq_out[7:0]  = drv_lo ? rd_data[7:0]  : 8'h00;
                dq_out[15:8] = drv_hi ? rd_data[15:8] : 8'h00;
            end
        end
    end

    assign dq_oe_lo  = drv_lo;
    assign dq_oe_hi  = drv_hi;
    assign rd_valid  = valid;
    assign proto_err = err;
endmodule

// File: rtl/sram_pin_target_chk.sv
module sram_pin_target_chk
    import sram_pin_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input tgt_state_e  st,
    input logic        narrow_s,
    input logic [15:0] dq_out,
    input logic        dq_oe_lo,
    input logic        dq_oe_hi,
    input logic        rd_valid,
    input logic        proto_err
);
    // R1: deselected means silent
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!dq_oe_lo && !dq_oe_hi && !rd_valid));

    // R3: no drive while a write window is open
    a_r3_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITE) |-> (!dq_oe_lo && !dq_oe_hi));

    // R4: outputs disabled state drives nothing
    a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OUT_OFF) |-> (!dq_oe_lo && !dq_oe_hi));

    // R6: byte mode never drives the upper lane
    a_r6_byte_top_off: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_s |-> !dq_oe_hi);

    // R8: placeholder is zero until valid
    a_r8_wait_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (dq_out == 16'h0000));

    // R9: error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(proto_err) |-> proto_err);
endmodule

bind sram_pin_target sram_pin_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .narrow_s  (narrow_s),
    .dq_out    (dq_out),
    .dq_oe_lo  (dq_oe_lo),
    .dq_oe_hi  (dq_oe_hi),
    .rd_valid  (rd_valid),
    .proto_err (proto_err)
);

// File: tb/sram_pin_target_bench.sv
module sram_pin_target_bench;
    localparam int AW  = 6;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs1_n = 1'b1, cs2 = 1'b0, narrow_n = 1'b1;
    logic          lo_en_n = 1'b1, hi_en_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out;
    logic          dq_oe_lo, dq_oe_hi, rd_valid, proto_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct packed {
        logic [15:0] data;
        logic        oe_lo;
        logic        oe_hi;
        logic [7:0]  tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    always #2 clk = ~clk;

    sram_pin_target #(.ADDR_W(AW), .LAT(LAT)) u_sram_pin_target (
        .clk, .rst_n, .cs1_n, .cs2, .narrow_n, .lo_en_n, .hi_en_n,
        .we_n, .oe_n, .addr, .dq_in, .dq_out, .dq_oe_lo, .dq_oe_hi,
        .rd_valid, .proto_err
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: pops expected read results and compares
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk($sformatf("R%0d read data", e.tag), {16'h0, dq_out}, {16'h0, e.data});
                chk($sformatf("R%0d lane enables", e.tag), {30'h0, dq_oe_hi, dq_oe_lo},
                    {30'h0, e.oe_hi, e.oe_lo});
                chk($sformatf("R%0d valid", e.tag), {31'h0, rd_valid}, 32'h1);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic ln,
                      input logic hn, input logic nar_n, input logic oe);
        cs1_n = 1'b0; cs2 = 1'b1; narrow_n = nar_n; lo_en_n = ln; hi_en_n = hn;
        addr = a; dq_in = d; oe_n = oe; we_n = 1'b1;
        cyc(3);
        we_n = 1'b0;
        cyc(5);
        chk("R3 no drive in write", {30'h0, dq_oe_hi, dq_oe_lo}, 32'h0);
        we_n = 1'b1; oe_n = 1'b1;
        cyc(4);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [15:0] d_in, input logic ln,
                      input logic hn, input logic nar_n, input logic [15:0] e_data,
                      input logic e_lo, input logic e_hi, input logic [7:0] tag);
        cs1_n = 1'b0; cs2 = 1'b1; narrow_n = nar_n; lo_en_n = ln; hi_en_n = hn;
        addr = a; dq_in = d_in; we_n = 1'b1; oe_n = 1'b0;
        cyc(3 + LAT + 2);
        exp_q.push_back('{data: e_data, oe_lo: e_lo, oe_hi: e_hi, tag: tag});
        ->sample_ev;
        cyc(1);
        oe_n = 1'b1;
        cyc(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        cyc(3);
        // R10: reset state
        chk("R10 oe after reset", {30'h0, dq_oe_hi, dq_oe_lo}, 32'h0);
        chk("R10 valid after reset", {31'h0, rd_valid}, 32'h0);
        chk("R10 err after reset", {31'h0, proto_err}, 32'h0);
        rst_n = 1'b1;
        cyc(3);
        rd(6'd5, 16'h0, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b1, 8'd10);

        // R3 / R5: word write with oe low, read back
        wr(6'd3, 16'hA5C3, 1'b0, 1'b0, 1'b1, 1'b0);
        rd(6'd3, 16'h0, 1'b0, 1'b0, 1'b1, 16'hA5C3, 1'b1, 1'b1, 8'd3);
        // R5: lower lane only write, then lane-limited reads
        wr(6'd3, 16'h1111, 1'b0, 1'b1, 1'b1, 1'b1);
        rd(6'd3, 16'h0, 1'b0, 1'b0, 1'b1, 16'hA511, 1'b1, 1'b1, 8'd5);
        rd(6'd3, 16'h0, 1'b0, 1'b1, 1'b1, 16'h0011, 1'b1, 1'b0, 8'd5);
        wr(6'd3, 16'h2200, 1'b1, 1'b0, 1'b1, 1'b1);
        rd(6'd3, 16'h0, 1'b1, 1'b0, 1'b1, 16'h2200, 1'b0, 1'b1, 8'd5);

        // R6: byte mode writes to both halves of word 7
        wr(6'd7, 16'h805A, 1'b0, 1'b0, 1'b0, 1'b1);
        rd(6'd7, 16'h8000, 1'b0, 1'b0, 1'b0, 16'h005A, 1'b1, 1'b0, 8'd6);
        rd(6'd7, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 8'd6);
        wr(6'd7, 16'h00C7, 1'b0, 1'b0, 1'b0, 1'b1);
        rd(6'd7, 16'h0, 1'b0, 1'b0, 1'b1, 16'h5AC7, 1'b1, 1'b1, 8'd6);

        // R7: close by we_n, then change data while still selected
        cs1_n = 1'b0; cs2 = 1'b1; narrow_n = 1'b1; lo_en_n = 1'b0; hi_en_n = 1'b0;
        oe_n = 1'b1; addr = 6'd9; dq_in = 16'h1234; we_n = 1'b1;
        cyc(3); we_n = 1'b0; cyc(4); we_n = 1'b1; cyc(3);
        dq_in = 16'hFFFF; cyc(4);
        rd(6'd9, 16'h0, 1'b0, 1'b0, 1'b1, 16'h1234, 1'b1, 1'b1, 8'd7);
        // R7: close by cs1_n, keep we_n low and change data
        addr = 6'd10; dq_in = 16'h4321; we_n = 1'b1; oe_n = 1'b1;
        cyc(3); we_n = 1'b0; cyc(4); cs1_n = 1'b1; cyc(3);
        dq_in = 16'hEEEE; cyc(4); we_n = 1'b1; cyc(3);
        rd(6'd10, 16'h0, 1'b0, 1'b0, 1'b1, 16'h4321, 1'b1, 1'b1, 8'd7);

        // R8: latency after address change during a read
        cs1_n = 1'b0; cs2 = 1'b1; narrow_n = 1'b1; lo_en_n = 1'b0; hi_en_n = 1'b0;
        addr = 6'd3; we_n = 1'b1; oe_n = 1'b0;
        cyc(10);
        chk("R8 valid before change", {31'h0, rd_valid}, 32'h1);
        addr = 6'd9;
        cyc(3);
        chk("R8 valid drops", {31'h0, rd_valid}, 32'h0);
        chk("R8 placeholder zero", {16'h0, dq_out}, 32'h0);
        cyc(LAT - 1);
        chk("R8 still waiting", {31'h0, rd_valid}, 32'h0);
        cyc(1);
        chk("R8 valid after latency", {31'h0, rd_valid}, 32'h1);
        chk("R8 data after latency", {16'h0, dq_out}, 32'h1234);

        // R4: both we_n and oe_n high drives nothing
        oe_n = 1'b1;
        cyc(4);
        chk("R4 output disabled", {29'h0, rd_valid, dq_oe_hi, dq_oe_lo}, 32'h0);

        // R1: cs2 low with write attempt: no drive, no write
        cs2 = 1'b0; addr = 6'd9; dq_in = 16'hDEAD; we_n = 1'b0;
        cyc(5);
        chk("R1 standby no drive", {29'h0, rd_valid, dq_oe_hi, dq_oe_lo}, 32'h0);
        we_n = 1'b1; cyc(3);
        rd(6'd9, 16'h0, 1'b0, 1'b0, 1'b1, 16'h1234, 1'b1, 1'b1, 8'd1);

        // R2: both enables high with write attempt
        cs1_n = 1'b0; cs2 = 1'b1; lo_en_n = 1'b1; hi_en_n = 1'b1;
        addr = 6'd9; dq_in = 16'hBEEF; oe_n = 1'b0; we_n = 1'b1;
        cyc(5);
        chk("R2 no drive", {29'h0, rd_valid, dq_oe_hi, dq_oe_lo}, 32'h0);
        we_n = 1'b0; cyc(5); we_n = 1'b1; cyc(3);
        rd(6'd9, 16'h0, 1'b0, 1'b0, 1'b1, 16'h1234, 1'b1, 1'b1, 8'd2);

        // R9: byte mode with an enable high
        chk("R9 err clear before", {31'h0, proto_err}, 32'h0);
        cs1_n = 1'b0; cs2 = 1'b1; narrow_n = 1'b0; lo_en_n = 1'b0; hi_en_n = 1'b1;
        we_n = 1'b1; oe_n = 1'b1;
        cyc(4);
        chk("R9 err set", {31'h0, proto_err}, 32'h1);
        narrow_n = 1'b1; hi_en_n = 1'b0;
        cyc(6);
        chk("R9 err sticky", {31'h0, proto_err}, 32'h1);
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(2);
        chk("R9 err cleared by reset", {31'h0, proto_err}, 32'h0);

        cyc(4);
        finish_run();
    end
endmodule